// File: doc/BRIEF.md
# Serial Register and Display-RAM Loader

This block is the write side of an on-screen character display controller. A host streams 16-bit words over a three-wire serial link made of an active-low select, a clock and a data line. The first word of each transfer is a start address. Every word after it is data for that address, and the address steps by one after each data word. The address space is shared. The lower 288 addresses go to a character display RAM and are sent out on a write port. The nine addresses directly above the RAM load nine 16-bit control registers, which the block drives as outputs.

Each RAM word carries an 8-bit character code in bits 7:0, foreground red/green/blue in bits 8/9/10, a blink flag in bit 11 and background colour in bits 14:12. The block passes the whole word to the RAM unchanged. The serial pins are sampled with the block's own clock through synchronisers. A word counts only once all 16 of its bits have arrived.

The block has two ways to erase the RAM. While the active-low clear is held low, every control register reads zero. Once clear is released, the block writes zero to all RAM words one after another and raises `busy` while it does so. Software can start the same sweep through a command bit in the last control register, and that path leaves the registers untouched. Serial words that finish while the sweep is running are dropped.

Top module: `osd_load_port`

## Requirements
- R1: While `clr_n` is low, all nine control registers read 0, `ram_we` is 0 and `busy` is 1.
- R2: After `clr_n` rises, the block writes data 0 to RAM addresses 0 to 287 in ascending order, one write per clock. `busy` stays high for exactly 288 clock samples, counted from the release.
- R3: Bits are taken on rising edges of `sck` while `cs_n` is low, most significant bit first, 16 bits to a word. The first word after `cs_n` falls is used in full as a 16-bit start address.
- R4: A data word whose current address is in 0x000 to 0x11F produces exactly one RAM write. The write carries that address and the word unchanged. `ram_addr` is always below 288 when `ram_we` is high.
- R5: The address steps by one after each data word, and the stepping continues from RAM addresses into register addresses.
- R6: A data word at address 0x120+k, for k from 0 to 8, loads control register k (bits 16k+15:16k of `ctrl_regs`) with bit 15 forced to 0.
- R7: Data words at addresses above 0x128 change no register and write nothing to the RAM.
- R8: An incomplete word that is still pending when `cs_n` rises is thrown away. The next transfer starts again with a start address.
- R9: Writing register 8 with bit 2 set starts the erase sweep. Bit 2 of register 8 always reads back 0, and the other registers keep their values.
- R10: A serial word that completes while `busy` is high has no effect on the registers or the RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also used to sample the serial pins |
| clr_n | input | 1 | Active-low asynchronous clear |
| cs_n | input | 1 | Active-low serial select |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data |
| ram_we | output | 1 | Display RAM write strobe |
| ram_addr | output | 9 | Display RAM write address |
| ram_wdata | output | 16 | Display RAM write data |
| ctrl_regs | output | 144 | Nine control registers, register k in bits 16k+15:16k |
| busy | output | 1 | High while the erase sweep runs |

## Verification
The serial path is driven with several kinds of transfer: a multi-word RAM burst, a burst that runs from the top of the RAM into register 0, a burst that runs past the last register into unused addresses, a transfer that starts in the unused space, and transfers cut off part way through a word. Together these separate correct framing and address stepping from shifted or misaligned words, writes that wrap round, and writes that leak into the wrong space. The erase sweep is started three ways: by releasing the clear at start-up, by the software command, and by pulsing the clear in the middle of the run. A full transfer sent while the software sweep runs shows whether busy-time words are really dropped.

// File: rtl/osd_load_pkg.sv
package osd_load_pkg;
    localparam int unsigned WORD_W    = 16;
    localparam int unsigned RAM_WORDS = 288;
    localparam int unsigned REG_COUNT = 9;
    localparam int unsigned ERASE_REG = 8;
    localparam int unsigned ERASE_BIT = 2;

    // layout of one display RAM word (passed through unchanged)
    typedef struct packed {
        logic       spare;
        logic [2:0] back_rgb;
        logic       blink;
        logic [2:0] fore_rgb;
        logic [7:0] code;
    } cell_t;
endpackage

// File: rtl/osd_ser_rx.sv
module osd_ser_rx #(
    parameter int unsigned WORD_W = osd_load_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdi,
    output logic              sel,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);
    localparam int unsigned CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [2:0]        sck_p;
        logic [1:0]        cs_p;
        logic [1:0]        sdi_p;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
        logic              vld;
        logic [WORD_W-1:0] word;
    } rx_t;

    rx_t rx_d, rx_q;
    logic rise;
    logic active;

    always_comb begin
        rx_d       = rx_q;
        rx_d.sck_p = {rx_q.sck_p[1:0], sck};
        rx_d.cs_p  = {rx_q.cs_p[0], cs_n};
        rx_d.sdi_p = {rx_q.sdi_p[0], sdi};
        rx_d.vld   = 1'b0;
        active     = ~rx_q.cs_p[1];
        rise       = rx_q.sck_p[1] & ~rx_q.sck_p[2];
        if (!active) begin
            rx_d.cnt = '0;
        end else if (rise) begin
            rx_d.sh = {rx_q.sh[WORD_W-2:0], rx_q.sdi_p[1]};
            if (rx_q.cnt == LAST_BIT) begin
                rx_d.cnt  = '0;
                rx_d.vld  = 1'b1;
                rx_d.word = {rx_q.sh[WORD_W-2:0], rx_q.sdi_p[1]};
            end else begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q.sck_p <= '0;
            rx_q.cs_p  <= '1;
            rx_q.sdi_p <= '0;
            rx_q.cnt   <= '0;
            rx_q.sh    <= '0;
            rx_q.vld   <= 1'b0;
            rx_q.word  <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign sel      = ~rx_q.cs_p[1];
    assign word_vld = rx_q.vld;
    assign word     = rx_q.word;
endmodule

// File: rtl/osd_wr_decode.sv
module osd_wr_decode #(
    parameter int unsigned WORD_W    = osd_load_pkg::WORD_W,
    parameter int unsigned RAM_WORDS = osd_load_pkg::RAM_WORDS,
    parameter int unsigned REG_COUNT = osd_load_pkg::REG_COUNT,
    parameter int unsigned ERASE_REG = osd_load_pkg::ERASE_REG,
    parameter int unsigned ERASE_BIT = osd_load_pkg::ERASE_BIT,
    localparam int unsigned RAM_AW   = $clog2(RAM_WORDS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sel,
    input  logic                          word_vld,
    input  logic [WORD_W-1:0]             word,
    input  logic                          busy,
    output logic                          req_we,
    output logic [RAM_AW-1:0]             req_addr,
    output logic [WORD_W-1:0]             req_data,
    output logic [REG_COUNT*WORD_W-1:0]   regs_flat,
    output logic                          erase_go
);
    localparam logic [WORD_W-1:0] REG_BASE = WORD_W'(RAM_WORDS);
    localparam logic [WORD_W-1:0] REG_END  = WORD_W'(RAM_WORDS + REG_COUNT);

    typedef struct packed {
        logic                                await_addr;
        logic [WORD_W-1:0]                   ptr;
        logic [REG_COUNT-1:0][WORD_W-1:0]    regs;
        logic                                we;
        logic [RAM_AW-1:0]                   wa;
        logic [WORD_W-1:0]                   wd;
        logic                                go;
    } dec_t;

    dec_t dec_d, dec_q;
    logic [WORD_W-1:0] reg_off;

    always_comb begin
        dec_d    = dec_q;
        dec_d.we = 1'b0;
        dec_d.go = 1'b0;
        reg_off  = dec_q.ptr - REG_BASE;
        if (!sel) begin
            dec_d.await_addr = 1'b1;
        end else if (word_vld && !busy) begin
            if (dec_q.await_addr) begin
                dec_d.ptr        = word;
                dec_d.await_addr = 1'b0;
            end else begin
                if (dec_q.ptr != '1) begin
                    dec_d.ptr = dec_q.ptr + 1'b1;
                end
                if (dec_q.ptr < REG_BASE) begin
                    dec_d.we = 1'b1;
                    dec_d.wa = dec_q.ptr[RAM_AW-1:0];
                    dec_d.wd = word;
                end else if (dec_q.ptr < REG_END) begin
                    for (int k = 0; k < int'(REG_COUNT); k++) begin
                        if (reg_off == WORD_W'(k)) begin
                            dec_d.regs[k] = {1'b0, word[WORD_W-2:0]};
                            if (k == int'(ERASE_REG) && word[ERASE_BIT]) begin
                                dec_d.regs[k][ERASE_BIT] = 1'b0;
                                dec_d.go                 = 1'b1;
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q.await_addr <= 1'b1;
            dec_q.ptr        <= '0;
            dec_q.regs       <= '0;
            dec_q.we         <= 1'b0;
            dec_q.wa         <= '0;
            dec_q.wd         <= '0;
            dec_q.go         <= 1'b0;
        end else begin
            dec_q <= dec_d;
        end
    end

    for (genvar g = 0; g < int'(REG_COUNT); g++) begin : g_regs
        assign regs_flat[g*WORD_W +: WORD_W] = dec_q.regs[g];
    end

    assign req_we   = dec_q.we;
    assign req_addr = dec_q.wa;
    assign req_data = dec_q.wd;
    assign erase_go = dec_q.go;
endmodule

// File: rtl/osd_erase_seq.sv
module osd_erase_seq #(
    parameter int unsigned RAM_WORDS = osd_load_pkg::RAM_WORDS,
    localparam int unsigned RAM_AW   = $clog2(RAM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              active,
    output logic [RAM_AW-1:0] idx
);
    localparam logic [RAM_AW-1:0] LAST_IDX = RAM_AW'(RAM_WORDS - 1);

    typedef struct packed {
        logic              run;
        logic [RAM_AW-1:0] cnt;
    } er_t;

    er_t er_d, er_q;

    always_comb begin
        er_d = er_q;
        if (er_q.run) begin
            if (er_q.cnt == LAST_IDX) begin
                er_d.run = 1'b0;
                er_d.cnt = '0;
            end else begin
                er_d.cnt = er_q.cnt + 1'b1;
            end
        end else if (start) begin
            er_d.run = 1'b1;
            er_d.cnt = '0;
        end
    end

    // clear leaves the sweep armed so it runs as soon as clear is released
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            er_q.run <= 1'b1;
            er_q.cnt <= '0;
        end else begin
            er_q <= er_d;
        end
    end

    assign active = er_q.run;
    assign idx    = er_q.cnt;
endmodule

// File: rtl/osd_load_port.sv
module osd_load_port #(
    parameter int unsigned WORD_W    = osd_load_pkg::WORD_W,
    parameter int unsigned RAM_WORDS = osd_load_pkg::RAM_WORDS,
    parameter int unsigned REG_COUNT = osd_load_pkg::REG_COUNT,
    parameter int unsigned ERASE_REG = osd_load_pkg::ERASE_REG,
    parameter int unsigned ERASE_BIT = osd_load_pkg::ERASE_BIT,
    localparam int unsigned RAM_AW   = $clog2(RAM_WORDS)
) (
    input  logic                        clk,
    input  logic                        clr_n,
    input  logic                        cs_n,
    input  logic                        sck,
    input  logic                        sdi,
    output logic                        ram_we,
    output logic [RAM_AW-1:0]           ram_addr,
    output logic [WORD_W-1:0]           ram_wdata,
    output logic [REG_COUNT*WORD_W-1:0] ctrl_regs,
    output logic                        busy
);
    typedef struct packed {
        logic              we;
        logic [RAM_AW-1:0] addr;
        logic [WORD_W-1:0] data;
    } port_t;

    logic              rx_sel, rx_vld;
    logic [WORD_W-1:0] rx_word;
    logic              req_we, er_go, er_active;
    logic [RAM_AW-1:0] req_addr, er_idx;
    logic [WORD_W-1:0] req_data;
    port_t             port_d, port_q;

    osd_ser_rx #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(clr_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .sel(rx_sel), .word_vld(rx_vld), .word(rx_word)
    );

    osd_wr_decode #(
        .WORD_W(WORD_W), .RAM_WORDS(RAM_WORDS), .REG_COUNT(REG_COUNT),
        .ERASE_REG(ERASE_REG), .ERASE_BIT(ERASE_BIT)
    ) u_dec (
        .clk(clk), .rst_n(clr_n), .sel(rx_sel), .word_vld(rx_vld),
        .word(rx_word), .busy(er_active), .req_we(req_we),
        .req_addr(req_addr), .req_data(req_data), .regs_flat(ctrl_regs),
        .erase_go(er_go)
    );

    osd_erase_seq #(.RAM_WORDS(RAM_WORDS)) u_erase (
        .clk(clk), .rst_n(clr_n), .start(er_go),
        .active(er_active), .idx(er_idx)
    );

    always_comb begin
        if (er_active) begin
            port_d.we   = 1'b1;
            port_d.addr = er_idx;
            port_d.data = '0;
        end else begin
            port_d.we   = req_we;
            port_d.addr = req_addr;
            port_d.data = req_data;
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            port_q <= '0;
        end else begin
            port_q <= port_d;
        end
    end

    assign ram_we    = port_q.we;
    assign ram_addr  = port_q.addr;
    assign ram_wdata = port_q.data;
    assign busy      = er_active;
endmodule

// File: rtl/osd_load_port_chk.sv
module osd_load_port_chk #(
    parameter int unsigned WORD_W    = osd_load_pkg::WORD_W,
    parameter int unsigned RAM_WORDS = osd_load_pkg::RAM_WORDS,
    parameter int unsigned REG_COUNT = osd_load_pkg::REG_COUNT,
    parameter int unsigned ERASE_REG = osd_load_pkg::ERASE_REG,
    parameter int unsigned ERASE_BIT = osd_load_pkg::ERASE_BIT,
    localparam int unsigned RAM_AW   = $clog2(RAM_WORDS)
) (
    input logic                        clk,
    input logic                        clr_n,
    input logic                        ram_we,
    input logic [RAM_AW-1:0]           ram_addr,
    input logic [WORD_W-1:0]           ram_wdata,
    input logic [REG_COUNT*WORD_W-1:0] ctrl_regs,
    input logic                        busy
);
    logic msb_any;
    always_comb begin
        msb_any = 1'b0;
        for (int k = 0; k < int'(REG_COUNT); k++) begin
            msb_any = msb_any | ctrl_regs[k*WORD_W + WORD_W - 1];
        end
    end

    AST_ERASE_ZERO_DATA: assert property (@(posedge clk) disable iff (!clr_n)
        busy && ram_we |-> ram_wdata == '0); // R2
    AST_ERASE_ADDR_STEP: assert property (@(posedge clk) disable iff (!clr_n)
        busy && ram_we && $past(busy && ram_we) |-> ram_addr == RAM_AW'($past(ram_addr) + 1'b1)); // R2
    AST_WR_ADDR_RANGE: assert property (@(posedge clk) disable iff (!clr_n)
        ram_we |-> ram_addr < RAM_AW'(RAM_WORDS)); // R4
    AST_REG_MSB_CLEAR: assert property (@(posedge clk) disable iff (!clr_n)
        !msb_any); // R6
    AST_ERASE_BIT_LOW: assert property (@(posedge clk) disable iff (!clr_n)
        !ctrl_regs[ERASE_REG*WORD_W + ERASE_BIT]); // R9
    AST_REGS_HOLD_BUSY: assert property (@(posedge clk) disable iff (!clr_n)
        busy && $past(busy) |-> $stable(ctrl_regs)); // R10
endmodule

bind osd_load_port osd_load_port_chk #(
    .WORD_W(WORD_W), .RAM_WORDS(RAM_WORDS), .REG_COUNT(REG_COUNT),
    .ERASE_REG(ERASE_REG), .ERASE_BIT(ERASE_BIT)
) u_chk (
    .clk(clk), .clr_n(clr_n), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ctrl_regs(ctrl_regs), .busy(busy)
);

// File: tb/osd_load_port_bench.sv
module osd_load_port_bench;
    logic         clk = 1'b0;
    logic         clr_n, cs_n, sck, sdi;
    logic         ram_we, busy;
    logic [8:0]   ram_addr;
    logic [15:0]  ram_wdata;
    logic [143:0] ctrl_regs;

    osd_load_port u_osd_load_port (
        .clk(clk), .clr_n(clr_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ctrl_regs(ctrl_regs), .busy(busy)
    );

    always #4 clk = ~clk;

    typedef struct { int a; int d; } wr_t;
    wr_t         exp_q[$];
    int          total = 0, fails = 0;
    int          erase_pend = 288;
    int          m_ptr = 0;
    logic [15:0] m_regs[9];
    bit          m_ignore = 0;
    bit          done = 0;
    int          cycles = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // every-clock comparison of the write port against the reference model
    always @(negedge clk) begin
        if (clr_n && !done && ram_we) begin
            if (erase_pend < 288) begin
                chk(ram_addr == 9'(erase_pend), "R2 erase addr", int'(ram_addr), erase_pend);
                chk(ram_wdata == 16'h0, "R2 erase data", int'(ram_wdata), 0);
                erase_pend++;
            end else if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected RAM write", int'(ram_addr), -1);
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                chk(ram_addr == 9'(e.a), "R4 ram addr", int'(ram_addr), e.a);
                chk(ram_wdata == 16'(e.d), "R4 ram data", int'(ram_wdata), e.d);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            chk(1'b0, "watchdog", cycles, 150000);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic bits_out(input logic [15:0] w, input int n);
        for (int i = 15; i > 15 - n; i--) begin
            sdi = w[i];
            repeat (3) @(negedge clk);
            sck = 1'b1;
            repeat (3) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic sel_low();
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic sel_high();
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic frame_begin(input int a);
        sel_low();
        bits_out(16'(a), 16);
        m_ptr = a;
    endtask

    task automatic frame_data(input logic [15:0] d);
        logic [15:0] v;
        bits_out(d, 16);
        if (!m_ignore) begin
            if (m_ptr < 288) begin
                exp_q.push_back('{m_ptr, int'(d)});
            end else if (m_ptr < 297) begin
                v = d & 16'h7fff;
                if (m_ptr == 296 && v[2]) begin
                    v[2] = 1'b0;
                    erase_pend = 0;
                end
                m_regs[m_ptr - 288] = v;
            end
            if (m_ptr != 65535) m_ptr++;
        end
    endtask

    task automatic check_regs(input string req);
        for (int k = 0; k < 9; k++) begin
            chk(ctrl_regs[k*16 +: 16] == m_regs[k], req, int'(ctrl_regs[k*16 +: 16]), int'(m_regs[k]));
        end
    endtask

    task automatic drain();
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R4 pending writes", exp_q.size(), 0);
    endtask

    initial begin
        int n;
        for (int k = 0; k < 9; k++) m_regs[k] = 16'h0;
        clr_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0;
        repeat (5) @(negedge clk);
        // R1 reset state
        check_regs("R1 regs in clear");
        chk(ram_we == 1'b0, "R1 we in clear", int'(ram_we), 0);
        chk(busy == 1'b1, "R1 busy in clear", int'(busy), 1);

        // R2 start-up sweep
        erase_pend = 0;
        clr_n = 1'b1;
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        chk(n == 288, "R2 busy length", n, 288);
        repeat (3) @(negedge clk);
        chk(erase_pend == 288, "R2 sweep count", erase_pend, 288);

        // R3 R4 R5: RAM burst
        frame_begin(16'h0005);
        frame_data(16'h1234);
        frame_data(16'hABCD);
        frame_data(16'h8001);
        sel_high();
        drain();

        // R5 R6: burst across RAM top into register 0 and 1
        frame_begin(16'h011E);
        frame_data(16'h0F1E);
        frame_data(16'h7A5A);
        frame_data(16'hFFFF);
        frame_data(16'h9C3C);
        sel_high();
        drain();
        check_regs("R6 reg load");

        // R7: run past last register
        frame_begin(16'h0127);
        frame_data(16'h4321);
        frame_data(16'h0001);
        frame_data(16'h5555);
        frame_data(16'h6666);
        sel_high();
        frame_begin(16'h0200);
        frame_data(16'h7777);
        sel_high();
        drain();
        check_regs("R7 above top");

        // R8: partial words discarded
        sel_low();
        bits_out(16'hFFFF, 7);
        sel_high();
        frame_begin(16'h0010);
        frame_data(16'h0F0F);
        bits_out(16'hAAAA, 5);
        sel_high();
        frame_begin(16'h0011);
        frame_data(16'h1111);
        sel_high();
        drain();

        // R9: software erase
        frame_begin(16'h0128);
        frame_data(16'h0005);
        sel_high();
        chk(busy == 1'b1, "R9 busy after command", int'(busy), 1);
        check_regs("R9 regs after command");

        // R10: transfer during sweep is dropped
        m_ignore = 1;
        frame_begin(16'h0120);
        frame_data(16'h0BAD);
        chk(busy == 1'b1, "R10 still busy", int'(busy), 1);
        sel_high();
        frame_begin(16'h0003);
        m_ignore = 0;
        cs_n = 1'b1;
        while (busy) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(erase_pend == 288, "R9 sweep count", erase_pend, 288);
        check_regs("R10 regs after sweep");
        drain();

        // R3 after sweep: fresh transfer works
        frame_begin(16'h0120);
        frame_data(16'h0042);
        sel_high();
        drain();
        check_regs("R3 reg after sweep");

        // R1 mid-run clear
        @(negedge clk);
        clr_n = 1'b0;
        for (int k = 0; k < 9; k++) m_regs[k] = 16'h0;
        repeat (3) @(negedge clk);
        check_regs("R1 regs mid clear");
        chk(busy == 1'b1, "R1 busy mid clear", int'(busy), 1);
        erase_pend = 0;
        clr_n = 1'b1;
        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(erase_pend == 288, "R2 sweep after clear", erase_pend, 288);
        chk(exp_q.size() == 0, "R4 queue empty", exp_q.size(), 0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule